// File: doc/BRIEF.md
# Privilege-Banked Instruction Namespace Register Unit

This block keeps, for every privilege level, three 32-bit namespace registers: the active namespace that the instruction decoder appends to each opcode, a saved namespace that holds the interrupted context's value while a trap handler runs, and a handler namespace (optionally a small table selected by trap cause). Software reaches all of them through a CSR-style request carrying a privilege level, an address and data. Writes are write-legal-read-legal: a value that the build does not support is never trimmed into a supported one. It is refused, and a one-cycle trap request goes back to the pipeline so that software can fall back to emulation.

Trap entry and trap return are run by a small sequencer. It rotates the three registers of the addressed privilege level in a fixed order, one register per cycle, and then raises a done strobe for one cycle. The pipeline may steer the program counter only while that strobe is high. The done strobe gates the pipeline's redirect request. The active namespace of the currently executing privilege level always feeds the decoder.

The sequencer has six states. S_IDLE goes to S_ENT_SAVE on a trap entry request and to S_RET_LOAD on a trap return request; entry wins when both arrive together. S_ENT_SAVE (saved <= active) goes to S_ENT_LOAD (active <= handler value). S_RET_LOAD (active <= saved) goes to S_RET_RST (saved <= handler value). Both S_ENT_LOAD and S_RET_RST go to S_DONE, and S_DONE always returns to S_IDLE.

Top module: `ns_csr_unit`

## Requirements
- R1: While reset is asserted and after its release, every register of every privilege level reads 0, the sequencer is idle, and swap_busy, swap_done, pc_redirect_en and csr_illegal are low.
- R2: A value with bit 0 = 0 (native mode) is legal only when all of the following hold. Bits 5:1 (16-bit opcode page) name a page in the supported set {0, 1, 8, 9}. Bit 6 (big-endian instruction order) is accepted. The bits set in 14:7 (feature field) are within mask 0x0F. Bits 23:15 are zero. The bits set in 31:24 (custom field) are within mask 0x81.
- R3: A value with bit 0 = 1 (foreign mode) is legal only when bits 7:1 hold a supported foreign index (0x10 or 0x40) and bits 31:8 are zero.
- R4: An accepted write of an illegal value raises csr_illegal in the same cycle as csr_wr_en, and leaves every register unchanged.
- R5: csr_addr[1:0] selects 0 = active, 1 = saved, 2 = handler, within the bank named by csr_priv. csr_rdata shows the selected register combinationally. Selector 3 reads 0, and any write to it is illegal. A legal write is visible on the cycle after the strobe.
- R6: Each privilege level has its own three registers. A write or swap on one level leaves the other levels unchanged.
- R7: On trap entry, the saved register takes the active value at the first edge after the request. The active register takes the handler value at the second edge.
- R8: On trap return, the active register takes the saved value at the first edge after the request. The saved register takes the handler value at the second edge.
- R9: swap_done is high for exactly one cycle, in the cycle after the final register update of a swap. pc_redirect_en equals pc_redirect_req AND swap_done.
- R10: The handler value is a table of four entries per level, selected by csr_addr[3:2] for CSR access and by the trap_cause latched with the request for swaps. Entry and return use the same index.
- R11: While swap_busy is high, CSR writes are ignored and never raise csr_illegal, and new trap requests are ignored. An entry request wins over a simultaneous return request.
- R12: decode_ns always equals the active register of the level given by cur_priv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_priv | input | PRIV_W | Privilege level that is executing |
| decode_ns | output | 32 | Active namespace handed to the decoder |
| csr_wr_en | input | 1 | Write strobe |
| csr_priv | input | PRIV_W | Bank addressed by the CSR access |
| csr_addr | input | CAUSE_W+2 | Register selector [1:0] and handler table entry [CAUSE_W+1:2] |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register |
| csr_illegal | output | 1 | Illegal-write trap request |
| trap_enter | input | 1 | Trap entry request |
| trap_return | input | 1 | Trap return request |
| trap_priv | input | PRIV_W | Level whose bank is swapped |
| trap_cause | input | CAUSE_W | Handler table index for the swap |
| pc_redirect_req | input | 1 | Pipeline wants to redirect the PC |
| swap_busy | output | 1 | Sequencer not idle |
| swap_done | output | 1 | Swap complete strobe |
| pc_redirect_en | output | 1 | PC redirect permitted |

## Verification
The bench goes after the order of the rotation. It reads the saved register in the middle of an entry swap, so a design that loaded the active register before saving it would show the handler value there, not the interrupted one. It presents writes that differ from a legal value by one reserved, feature or custom bit, and foreign values with stray upper bits. A design that masked these instead of refusing them would change a register without raising the trap request. It writes to a handler table entry and issues an illegal write while a swap is running, which a design without the busy guard would let through. It also sends entry and return together, and a design with the wrong priority would leave the saved register holding the wrong value.

// File: rtl/ns_pkg.sv
package ns_pkg;

    typedef logic [31:0] ns_word_t;

    // Register selector within one privilege bank
    typedef enum logic [1:0] {
        K_ACT  = 2'd0,
        K_LAST = 2'd1,
        K_TRAP = 2'd2,
        K_NONE = 2'd3
    } ns_kind_e;

    // Register movement requested by the sequencer
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_SAVE  = 3'd1,
        OP_LOADT = 3'd2,
        OP_LOADL = 3'd3,
        OP_RSTL  = 3'd4
    } ns_op_e;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_ENT_SAVE = 3'd1,
        S_ENT_LOAD = 3'd2,
        S_RET_LOAD = 3'd3,
        S_RET_RST  = 3'd4,
        S_DONE     = 3'd5
    } swap_state_e;

    // Field layout of a namespace word
    localparam int MODE_BIT = 0;
    localparam int PAGE_LO  = 1;
    localparam int PAGE_W   = 5;
    localparam int END_BIT  = 6;
    localparam int FEAT_LO  = 7;
    localparam int FEAT_W   = 8;
    localparam int RSV_LO   = 15;
    localparam int RSV_W    = 9;
    localparam int CUST_LO  = 24;
    localparam int CUST_W   = 8;
    localparam int FIDX_LO  = 1;
    localparam int FIDX_W   = 7;
    localparam int FA_HI_LO = FIDX_LO + FIDX_W;

endpackage

// File: rtl/ns_legal.sv
module ns_legal
    import ns_pkg::*;
#(
    parameter logic [(1<<PAGE_W)-1:0] PAGE_OK    = 32'h0000_0303,
    parameter logic [FEAT_W-1:0]      FEAT_OK    = 8'h0F,
    parameter logic [CUST_W-1:0]      CUSTOM_OK  = 8'h81,
    parameter bit                     BIGEND_OK  = 1'b1,
    parameter logic [(1<<FIDX_W)-1:0] FOREIGN_OK = 128'h0000_0000_0000_0001_0000_0000_0001_0000
) (
    input  ns_word_t value,
    output logic     legal
);

    logic [PAGE_W-1:0] page;
    logic [FIDX_W-1:0] fidx;
    logic              native_ok;
    logic              foreign_ok;

    always_comb begin
        page = value[PAGE_LO +: PAGE_W];
        fidx = value[FIDX_LO +: FIDX_W];

        native_ok = PAGE_OK[page]
                 && (BIGEND_OK || !value[END_BIT])
                 && ((value[FEAT_LO +: FEAT_W] & ~FEAT_OK) == '0)
                 && (value[RSV_LO +: RSV_W] == '0)
                 && ((value[CUST_LO +: CUST_W] & ~CUSTOM_OK) == '0);

        foreign_ok = FOREIGN_OK[fidx] && (value[31:FA_HI_LO] == '0);

        legal = value[MODE_BIT] ? foreign_ok : native_ok;
    end

endmodule

// File: rtl/ns_bank.sv
module ns_bank
    import ns_pkg::*;
#(
    parameter int PRIV_W     = 2,
    parameter int CAUSE_W    = 2,
    parameter bit TRAP_TABLE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PRIV_W-1:0]   wr_priv,
    input  ns_kind_e            wr_kind,
    input  logic [CAUSE_W-1:0]  wr_idx,
    input  ns_word_t            wr_data,
    input  ns_op_e              op,
    input  logic [PRIV_W-1:0]   op_priv,
    input  logic [CAUSE_W-1:0]  op_cause,
    input  logic [PRIV_W-1:0]   rd_priv,
    input  ns_kind_e            rd_kind,
    input  logic [CAUSE_W-1:0]  rd_idx,
    output ns_word_t            rd_data,
    input  logic [PRIV_W-1:0]   dec_priv,
    output ns_word_t            dec_ns
);

    localparam int NPRIV = 1 << PRIV_W;
    localparam int IDX_W = TRAP_TABLE ? CAUSE_W : 1;
    localparam int NTRAP = 1 << IDX_W;

    ns_word_t act_q  [NPRIV];
    ns_word_t last_q [NPRIV];
    ns_word_t trap_q [NPRIV][NTRAP];

    logic [IDX_W-1:0] wsel;
    logic [IDX_W-1:0] osel;
    logic [IDX_W-1:0] rsel;

    // Handler value: per-cause table or one register per level
    if (TRAP_TABLE) begin : g_table
        assign wsel = wr_idx;
        assign osel = op_cause;
        assign rsel = rd_idx;
    end else begin : g_single
        assign wsel = '0;
        assign osel = '0;
        assign rsel = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPRIV; p++) begin
                act_q[p]  <= '0;
                last_q[p] <= '0;
                for (int e = 0; e < NTRAP; e++) begin
                    trap_q[p][e] <= '0;
                end
            end
        end else begin
            if (wr_en) begin
                case (wr_kind)
                    K_ACT:   act_q[wr_priv]        <= wr_data;
                    K_LAST:  last_q[wr_priv]       <= wr_data;
                    K_TRAP:  trap_q[wr_priv][wsel] <= wr_data;
                    default: ;
                endcase
            end
            case (op)
                OP_SAVE:  last_q[op_priv] <= act_q[op_priv];
                OP_LOADT: act_q[op_priv]  <= trap_q[op_priv][osel];
                OP_LOADL: act_q[op_priv]  <= last_q[op_priv];
                OP_RSTL:  last_q[op_priv] <= trap_q[op_priv][osel];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_kind)
            K_ACT:   rd_data = act_q[rd_priv];
            K_LAST:  rd_data = last_q[rd_priv];
            K_TRAP:  rd_data = trap_q[rd_priv][rsel];
            default: rd_data = '0;
        endcase
    end

    assign dec_ns = act_q[dec_priv];

endmodule

// File: rtl/ns_swap_fsm.sv
module ns_swap_fsm
    import ns_pkg::*;
#(
    parameter int PRIV_W  = 2,
    parameter int CAUSE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_enter,
    input  logic               trap_return,
    input  logic [PRIV_W-1:0]  trap_priv,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic               pc_redirect_req,
    output ns_op_e             op,
    output logic [PRIV_W-1:0]  op_priv,
    output logic [CAUSE_W-1:0] op_cause,
    output logic               busy,
    output logic               swap_done,
    output logic               pc_redirect_en
);

    swap_state_e        state_q;
    swap_state_e        state_d;
    logic [PRIV_W-1:0]  priv_q;
    logic [CAUSE_W-1:0] cause_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            priv_q  <= '0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && (trap_enter || trap_return)) begin
                priv_q  <= trap_priv;
                cause_q <= trap_cause;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (trap_enter)       state_d = S_ENT_SAVE;
                else if (trap_return) state_d = S_RET_LOAD;
            end
            S_ENT_SAVE: state_d = S_ENT_LOAD;
            S_ENT_LOAD: state_d = S_DONE;
            S_RET_LOAD: state_d = S_RET_RST;
            S_RET_RST:  state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_comb begin
        op        = OP_HOLD;
        busy      = 1'b1;
        swap_done = 1'b0;
        unique case (state_q)
            S_IDLE:     busy      = 1'b0;
            S_ENT_SAVE: op        = OP_SAVE;
            S_ENT_LOAD: op        = OP_LOADT;
            S_RET_LOAD: op        = OP_LOADL;
            S_RET_RST:  op        = OP_RSTL;
            S_DONE:     swap_done = 1'b1;
            default:    busy      = 1'b0;
        endcase
        pc_redirect_en = swap_done && pc_redirect_req;
    end

    assign op_priv  = priv_q;
    assign op_cause = cause_q;

endmodule

// File: rtl/ns_csr_unit.sv
module ns_csr_unit
    import ns_pkg::*;
#(
    parameter int                     PRIV_W     = 2,
    parameter int                     CAUSE_W    = 2,
    parameter bit                     TRAP_TABLE = 1'b1,
    parameter logic [(1<<PAGE_W)-1:0] PAGE_OK    = 32'h0000_0303,
    parameter logic [FEAT_W-1:0]      FEAT_OK    = 8'h0F,
    parameter logic [CUST_W-1:0]      CUSTOM_OK  = 8'h81,
    parameter bit                     BIGEND_OK  = 1'b1,
    parameter logic [(1<<FIDX_W)-1:0] FOREIGN_OK = 128'h0000_0000_0000_0001_0000_0000_0001_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PRIV_W-1:0]   cur_priv,
    output logic [31:0]         decode_ns,
    input  logic                csr_wr_en,
    input  logic [PRIV_W-1:0]   csr_priv,
    input  logic [CAUSE_W+1:0]  csr_addr,
    input  logic [31:0]         csr_wdata,
    output logic [31:0]         csr_rdata,
    output logic                csr_illegal,
    input  logic                trap_enter,
    input  logic                trap_return,
    input  logic [PRIV_W-1:0]   trap_priv,
    input  logic [CAUSE_W-1:0]  trap_cause,
    input  logic                pc_redirect_req,
    output logic                swap_busy,
    output logic                swap_done,
    output logic                pc_redirect_en
);

    ns_kind_e           kind;
    logic [CAUSE_W-1:0] tbl_idx;
    logic               value_ok;
    logic               wr_live;
    logic               wr_commit;
    ns_op_e             op;
    logic [PRIV_W-1:0]  op_priv;
    logic [CAUSE_W-1:0] op_cause;

    assign kind    = ns_kind_e'(csr_addr[1:0]);
    assign tbl_idx = csr_addr[CAUSE_W+1:2];

    ns_legal #(
        .PAGE_OK    (PAGE_OK),
        .FEAT_OK    (FEAT_OK),
        .CUSTOM_OK  (CUSTOM_OK),
        .BIGEND_OK  (BIGEND_OK),
        .FOREIGN_OK (FOREIGN_OK)
    ) u_legal (
        .value (csr_wdata),
        .legal (value_ok)
    );

    // Writes are only taken while the sequencer is idle
    assign wr_live     = csr_wr_en && !swap_busy;
    assign wr_commit   = wr_live && value_ok && (kind != K_NONE);
    assign csr_illegal = wr_live && !(value_ok && (kind != K_NONE));

    ns_swap_fsm #(
        .PRIV_W  (PRIV_W),
        .CAUSE_W (CAUSE_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .trap_enter      (trap_enter),
        .trap_return     (trap_return),
        .trap_priv       (trap_priv),
        .trap_cause      (trap_cause),
        .pc_redirect_req (pc_redirect_req),
        .op              (op),
        .op_priv         (op_priv),
        .op_cause        (op_cause),
        .busy            (swap_busy),
        .swap_done       (swap_done),
        .pc_redirect_en  (pc_redirect_en)
    );

    ns_bank #(
        .PRIV_W     (PRIV_W),
        .CAUSE_W    (CAUSE_W),
        .TRAP_TABLE (TRAP_TABLE)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_commit),
        .wr_priv  (csr_priv),
        .wr_kind  (kind),
        .wr_idx   (tbl_idx),
        .wr_data  (csr_wdata),
        .op       (op),
        .op_priv  (op_priv),
        .op_cause (op_cause),
        .rd_priv  (csr_priv),
        .rd_kind  (kind),
        .rd_idx   (tbl_idx),
        .rd_data  (csr_rdata),
        .dec_priv (cur_priv),
        .dec_ns   (decode_ns)
    );

endmodule

// File: rtl/ns_csr_unit_sva.sv
module ns_csr_unit_sva #(
    parameter int PRIV_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PRIV_W-1:0] cur_priv,
    input logic [31:0]       decode_ns,
    input logic              csr_wr_en,
    input logic              csr_illegal,
    input logic              trap_enter,
    input logic              pc_redirect_req,
    input logic              swap_busy,
    input logic              swap_done,
    input logic              pc_redirect_en
);

    assert_illegal_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_wr_en);

    assert_illegal_keeps_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> (decode_ns == $past(decode_ns)) || (cur_priv != $past(cur_priv)));

    assert_no_trap_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        swap_busy |-> !csr_illegal);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |=> !swap_done);

    assert_redirect_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect_en |-> (swap_done && pc_redirect_req));

    assert_entry_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_enter && !swap_busy) |=> swap_busy);

    assert_done_after_rotation_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swap_done |-> ($past(swap_busy) && $past(swap_busy, 2)));

endmodule

bind ns_csr_unit ns_csr_unit_sva #(.PRIV_W(PRIV_W)) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .cur_priv        (cur_priv),
    .decode_ns       (decode_ns),
    .csr_wr_en       (csr_wr_en),
    .csr_illegal     (csr_illegal),
    .trap_enter      (trap_enter),
    .pc_redirect_req (pc_redirect_req),
    .swap_busy       (swap_busy),
    .swap_done       (swap_done),
    .pc_redirect_en  (pc_redirect_en)
);

// File: tb/sim_ns_csr_unit.sv
module sim_ns_csr_unit;

    localparam int PW = 2;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] cur_priv = '0;
    logic [31:0]   decode_ns;
    logic          csr_wr_en = 1'b0;
    logic [PW-1:0] csr_priv = '0;
    logic [CW+1:0] csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          csr_illegal;
    logic          trap_enter = 1'b0;
    logic          trap_return = 1'b0;
    logic [PW-1:0] trap_priv = '0;
    logic [CW-1:0] trap_cause = '0;
    logic          pc_redirect_req = 1'b0;
    logic          swap_busy;
    logic          swap_done;
    logic          pc_redirect_en;

    always #4 clk = ~clk;

    ns_csr_unit #(.PRIV_W(PW), .CAUSE_W(CW), .TRAP_TABLE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cur_priv(cur_priv), .decode_ns(decode_ns),
        .csr_wr_en(csr_wr_en), .csr_priv(csr_priv), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
        .trap_enter(trap_enter), .trap_return(trap_return), .trap_priv(trap_priv),
        .trap_cause(trap_cause), .pc_redirect_req(pc_redirect_req),
        .swap_busy(swap_busy), .swap_done(swap_done), .pc_redirect_en(pc_redirect_en)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_act  [4];
    logic [31:0] m_last [4];
    logic [31:0] m_trap [4][4];
    int          m_phase;   // 0 idle, 1 save, 2 load-handler, 3 load-saved, 4 reset-saved, 5 done
    logic [1:0]  m_priv;
    logic [1:0]  m_cause;

    function automatic bit value_ok(input logic [31:0] v);
        logic [6:0] fi;
        logic [4:0] pg;
        if (v[0]) begin
            fi = v[7:1];
            return (v[31:8] == 24'd0) && (fi == 7'h10 || fi == 7'h40);
        end
        pg = v[5:1];
        return (pg == 5'd0 || pg == 5'd1 || pg == 5'd8 || pg == 5'd9)
            && ((v[14:7] & 8'hF0) == 8'd0)
            && (v[23:15] == 9'd0)
            && ((v[31:24] & 8'h7E) == 8'd0);
    endfunction

    task automatic model_clear();
        for (int p = 0; p < 4; p++) begin
            m_act[p]  = '0;
            m_last[p] = '0;
            for (int e = 0; e < 4; e++) m_trap[p][e] = '0;
        end
        m_phase = 0;
        m_priv  = '0;
        m_cause = '0;
    endtask

    initial model_clear();

    always @(negedge clk) begin
        logic [1:0]  sel;
        logic [1:0]  ent;
        logic [31:0] exp_rd;
        logic        exp_ill;
        logic        takes;
        #3;
        sel = csr_addr[1:0];
        ent = csr_addr[3:2];
        exp_rd = (sel == 2'd0) ? m_act[csr_priv] :
                 (sel == 2'd1) ? m_last[csr_priv] :
                 (sel == 2'd2) ? m_trap[csr_priv][ent] : 32'd0;
        takes   = csr_wr_en && (m_phase == 0);
        exp_ill = takes && !(sel != 2'd3 && value_ok(csr_wdata));
        check("R12 decode_ns", decode_ns, m_act[cur_priv]);
        check("R5 csr_rdata", csr_rdata, exp_rd);
        check("R4 csr_illegal", {31'd0, csr_illegal}, {31'd0, exp_ill});
        check("R11 swap_busy", {31'd0, swap_busy}, {31'd0, m_phase != 0});
        check("R9 swap_done", {31'd0, swap_done}, {31'd0, m_phase == 5});
        check("R9 pc_redirect_en", {31'd0, pc_redirect_en},
              {31'd0, (m_phase == 5) && pc_redirect_req});
        if (!rst_n) begin
            model_clear();
        end else begin
            if (takes && sel != 2'd3 && value_ok(csr_wdata)) begin
                if (sel == 2'd0) m_act[csr_priv] = csr_wdata;
                else if (sel == 2'd1) m_last[csr_priv] = csr_wdata;
                else m_trap[csr_priv][ent] = csr_wdata;
            end
            case (m_phase)
                0: if (trap_enter) begin
                       m_phase = 1; m_priv = trap_priv; m_cause = trap_cause;
                   end else if (trap_return) begin
                       m_phase = 3; m_priv = trap_priv; m_cause = trap_cause;
                   end
                1: begin m_last[m_priv] = m_act[m_priv];          m_phase = 2; end
                2: begin m_act[m_priv]  = m_trap[m_priv][m_cause]; m_phase = 5; end
                3: begin m_act[m_priv]  = m_last[m_priv];          m_phase = 4; end
                4: begin m_last[m_priv] = m_trap[m_priv][m_cause]; m_phase = 5; end
                default: m_phase = 0;
            endcase
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic wr(input logic [1:0] p, input logic [3:0] a, input logic [31:0] d,
                      input logic exp_ill, input string req);
        csr_wr_en = 1'b1; csr_priv = p; csr_addr = a; csr_wdata = d;
        #1;
        check(req, {31'd0, csr_illegal}, {31'd0, exp_ill});
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] p, input logic [3:0] a, input logic [31:0] exp,
                      input string req);
        csr_priv = p; csr_addr = a;
        #1;
        check(req, csr_rdata, exp);
        @(negedge clk);
    endtask

    task automatic trap(input logic en, input logic rt, input logic [1:0] p, input logic [1:0] c);
        trap_enter = en; trap_return = rt; trap_priv = p; trap_cause = c;
        @(negedge clk);
        trap_enter = 1'b0; trap_return = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", 200000);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset decode", decode_ns, 32'd0);
        check("R1 reset busy", {31'd0, swap_busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++)
                rd(p[1:0], k[3:0], 32'd0, "R1 zero after reset");

        // R2 native-mode values
        wr(2'd1, 4'd0, 32'h0000_0002, 1'b0, "R2 page 1");
        rd(2'd1, 4'd0, 32'h0000_0002, "R2 page 1 stored");
        wr(2'd1, 4'd0, 32'h0000_0052, 1'b0, "R2 page 9 big-endian");
        wr(2'd1, 4'd1, 32'h8100_0780, 1'b0, "R2 feature and custom bits");
        rd(2'd1, 4'd1, 32'h8100_0780, "R2 saved reg stored");
        wr(2'd1, 4'd0, 32'h0000_0004, 1'b1, "R2 unsupported page");
        wr(2'd1, 4'd0, 32'h0000_0800, 1'b1, "R2 unsupported feature bit");
        wr(2'd1, 4'd0, 32'h0000_8000, 1'b1, "R2 reserved bit");
        wr(2'd1, 4'd0, 32'h0200_0000, 1'b1, "R2 unsupported custom bit");
        rd(2'd1, 4'd0, 32'h0000_0052, "R4 illegal writes left value");

        // R3 foreign-mode values
        wr(2'd2, 4'd0, 32'h0000_0021, 1'b0, "R3 official foreign index");
        wr(2'd2, 4'd0, 32'h0000_0081, 1'b0, "R3 custom foreign index");
        wr(2'd2, 4'd0, 32'h0000_0023, 1'b1, "R3 unsupported foreign index");
        wr(2'd2, 4'd0, 32'h0000_0121, 1'b1, "R3 stray upper bit");
        rd(2'd2, 4'd0, 32'h0000_0081, "R3 foreign kept");

        // R5 selector 3, R6 bank separation
        wr(2'd0, 4'd3, 32'h0000_0002, 1'b1, "R5 selector 3 write");
        rd(2'd0, 4'd3, 32'd0, "R5 selector 3 read");
        rd(2'd0, 4'd0, 32'd0, "R6 level 0 untouched");
        rd(2'd3, 4'd0, 32'd0, "R6 level 3 untouched");

        // R10 handler table for level 1
        wr(2'd1, 4'b0010, 32'h0000_0012, 1'b0, "R10 entry 0");
        wr(2'd1, 4'b0110, 32'h0000_0021, 1'b0, "R10 entry 1");
        wr(2'd1, 4'b1010, 32'h0000_0081, 1'b0, "R10 entry 2");
        wr(2'd1, 4'b1110, 32'h0000_0002, 1'b0, "R10 entry 3");
        rd(2'd1, 4'b0110, 32'h0000_0021, "R10 entry 1 readback");
        rd(2'd1, 4'b1010, 32'h0000_0081, "R10 entry 2 readback");

        // R7 trap entry on level 1, cause 2
        cur_priv = 2'd1;
        pc_redirect_req = 1'b1;
        csr_priv = 2'd1; csr_addr = 4'd1;
        trap(1'b1, 1'b0, 2'd1, 2'd2);
        #1;
        check("R7 busy after request", {31'd0, swap_busy}, 32'd1);
        check("R7 active before save", decode_ns, 32'h0000_0052);
        @(negedge clk); #1;
        check("R7 saved first", csr_rdata, 32'h0000_0052);
        check("R7 active not yet loaded", decode_ns, 32'h0000_0052);
        @(negedge clk); #1;
        check("R7 handler value loaded", decode_ns, 32'h0000_0081);
        check("R9 done after load", {31'd0, swap_done}, 32'd1);
        check("R9 redirect enabled", {31'd0, pc_redirect_en}, 32'd1);
        @(negedge clk); #1;
        check("R9 done one cycle", {31'd0, swap_done}, 32'd0);
        @(negedge clk);

        // R8 trap return on level 1, cause 2, no redirect request
        pc_redirect_req = 1'b0;
        trap(1'b0, 1'b1, 2'd1, 2'd2);
        #1;
        check("R8 active before restore", decode_ns, 32'h0000_0081);
        @(negedge clk); #1;
        check("R8 active restored", decode_ns, 32'h0000_0052);
        check("R8 saved not yet reset", csr_rdata, 32'h0000_0052);
        @(negedge clk); #1;
        check("R8 saved reset to handler", csr_rdata, 32'h0000_0081);
        check("R9 redirect withheld", {31'd0, pc_redirect_en}, 32'd0);
        @(negedge clk);
        @(negedge clk);

        // R11 writes ignored while busy
        trap(1'b1, 1'b0, 2'd1, 2'd0);
        wr(2'd1, 4'b1110, 32'h0000_0021, 1'b0, "R11 write ignored while busy");
        wr(2'd1, 4'd0, 32'h0000_8000, 1'b0, "R11 no trap while busy");
        @(negedge clk);
        rd(2'd1, 4'b1110, 32'h0000_0002, "R11 table entry unchanged");
        rd(2'd1, 4'd0, 32'h0000_0012, "R10 entry by cause 0");
        rd(2'd1, 4'd1, 32'h0000_0052, "R7 saved value");

        // R11 entry wins over return
        trap(1'b1, 1'b1, 2'd2, 2'd1);
        repeat (3) @(negedge clk);
        rd(2'd2, 4'd1, 32'h0000_0081, "R11 entry priority");
        rd(2'd2, 4'd0, 32'h0000_0000, "R11 entry priority active");

        // R11 requests while busy ignored
        wr(2'd3, 4'd0, 32'h0000_0002, 1'b0, "R6 level 3 write");
        trap(1'b1, 1'b0, 2'd3, 2'd0);
        trap(1'b0, 1'b1, 2'd3, 2'd0);
        repeat (4) @(negedge clk);
        cur_priv = 2'd3;
        rd(2'd3, 4'd1, 32'h0000_0002, "R11 return while busy ignored");
        #1;
        check("R12 decode follows level 3", decode_ns, 32'h0000_0000);
        rd(2'd1, 4'd0, 32'h0000_0012, "R6 level 1 untouched by level 3");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule